// File: doc/BRIEF.md
# Processor status flags register

This block holds the eight-bit condition register of a processor with a 16-bit datapath. It combines three kinds of bit. Zero and sign are taken from whichever accumulator is currently selected. Overflow, carry and equals are captured from the latest add, subtract or compare result. Two general-purpose bits belong to software.

The datapath presents four inputs to the block:
- the active accumulator value;
- a strobe for each add or subtract, together with the carry-outs of bits 14 and 15 of that operation;
- a strobe for each compare, together with its equality result;
- a byte-wide register write from software.

Every bit of the readback comes from a register. Any input change therefore appears on the readback on the clock edge that samples it, and is visible in the following cycle. Flag bit positions are fixed: Z=7, S=6, bit 5 reserved, general-purpose bits G=4:3, OV=2, C=1, E=0.

Top module: `psf_flags`

## Requirements
- R1: While `rst` is high at a clock edge, the readback becomes 80h (Z=1, all other bits 0). Every bit of `flags_o` updates at the clock edge that samples its inputs.
- R2: Bit 7 (zero) reads 1 when the sampled `acc_i` was all zeros, and 0 otherwise.
- R3: Bit 6 (sign) reads the sampled value of bit 15 of `acc_i`.
- R4: On an `arith_vld` cycle, bit 2 (overflow) captures `c14_i` XOR `c15_i`. Without `arith_vld` it holds its value, and software writes do not change it.
- R5: On an `arith_vld` cycle, bit 1 (carry) captures `c15_i`. Otherwise a software write loads `wr_data[1]` into it, and with neither it holds.
- R6: On a `cmp_vld` cycle, bit 0 (equals) captures `cmp_eq`. Otherwise a software write loads `wr_data[0]` into it, and with neither it holds.
- R7: A software write loads `wr_data[4:3]` into bits 4:3. Without a write these bits hold.
- R8: Bit 5 always reads 0. Software writes to bits 7, 6, 5 and 2 have no effect on the readback.
- R9: When a hardware strobe and a software write target carry or equals in the same cycle, the hardware value is the one stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | 16 | Active accumulator value |
| arith_vld | input | 1 | Add/subtract result strobe |
| c14_i | input | 1 | Carry out of bit 14 of that result |
| c15_i | input | 1 | Carry/borrow out of bit 15 of that result |
| cmp_vld | input | 1 | Compare result strobe |
| cmp_eq | input | 1 | Compare found equality |
| wr_en | input | 1 | Software register write |
| wr_data | input | 8 | Software write data |
| flags_o | output | 8 | Register readback |

## Verification
Directed cases cover the accumulator boundaries: zero, 8000h, 0001h and FFFFh. These separate the zero test from the sign tap. All four combinations of the two carry-outs are applied, which shows that overflow is an exclusive-or and not a copy of either carry.

An all-ones write on an idle cycle exposes any leak into the reserved and read-only bits. Writes that coincide with each strobe tell the hardware-priority path apart from the software path.

Random mixes of strobes, writes and accumulator values then confirm that every latched flag holds when nothing addresses it.

// File: rtl/psf_pkg.sv
package psf_pkg;
  localparam int REG_W = 8;
  localparam int BIT_Z = 7;
  localparam int BIT_S = 6;
  localparam int BIT_G_HI = 4;
  localparam int BIT_G_LO = 3;
  localparam int BIT_OV = 2;
  localparam int BIT_C = 1;
  localparam int BIT_E = 0;
  localparam int GPF_W = BIT_G_HI - BIT_G_LO + 1;
endpackage

// File: rtl/psf_live.sv
module psf_live #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] acc_i,
  output logic              zero_q,
  output logic              sign_q
);
  localparam int MSB = DATA_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_q <= 1'b1;
      sign_q <= 1'b0;
    end else begin
      zero_q <= (acc_i == '0);
      sign_q <= acc_i[MSB];
    end
  end
endmodule

// File: rtl/psf_arith.sv
module psf_arith (
  input  logic clk,
  input  logic rst,
  input  logic arith_vld,
  input  logic c14_i,
  input  logic c15_i,
  input  logic sw_we,
  input  logic sw_c,
  output logic ov_q,
  output logic c_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q <= 1'b0;
      c_q  <= 1'b0;
    end else if (arith_vld) begin
      ov_q <= c14_i ^ c15_i;
      c_q  <= c15_i;
    end else if (sw_we) begin
      c_q  <= sw_c;
    end
  end
endmodule

// File: rtl/psf_soft.sv
module psf_soft #(
  parameter int GPF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_vld,
  input  logic             cmp_eq,
  input  logic             sw_we,
  input  logic             sw_e,
  input  logic [GPF_W-1:0] sw_gpf,
  output logic             e_q,
  output logic [GPF_W-1:0] gpf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      e_q   <= 1'b0;
      gpf_q <= '0;
    end else begin
      if (cmp_vld)    e_q <= cmp_eq;
      else if (sw_we) e_q <= sw_e;
      if (sw_we)      gpf_q <= sw_gpf;
    end
  end
endmodule

// File: rtl/psf_flags.sv
module psf_flags
  import psf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              arith_vld,
  input  logic              c14_i,
  input  logic              c15_i,
  input  logic              cmp_vld,
  input  logic              cmp_eq,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  flags_o
);
  logic             zero_q, sign_q, ov_q, c_q, e_q;
  logic [GPF_W-1:0] gpf_q;

  psf_live #(.DATA_W(DATA_W)) u_live (
    .clk(clk), .rst(rst), .acc_i(acc_i), .zero_q(zero_q), .sign_q(sign_q)
  );

  psf_arith u_arith (
    .clk(clk), .rst(rst), .arith_vld(arith_vld), .c14_i(c14_i), .c15_i(c15_i),
    .sw_we(wr_en), .sw_c(wr_data[BIT_C]), .ov_q(ov_q), .c_q(c_q)
  );

  psf_soft #(.GPF_W(GPF_W)) u_soft (
    .clk(clk), .rst(rst), .cmp_vld(cmp_vld), .cmp_eq(cmp_eq),
    .sw_we(wr_en), .sw_e(wr_data[BIT_E]), .sw_gpf(wr_data[BIT_G_HI:BIT_G_LO]),
    .e_q(e_q), .gpf_q(gpf_q)
  );

  always_comb begin
    flags_o                   = '0;
    flags_o[BIT_Z]            = zero_q;
    flags_o[BIT_S]            = sign_q;
    flags_o[BIT_G_HI:BIT_G_LO] = gpf_q;
    flags_o[BIT_OV]           = ov_q;
    flags_o[BIT_C]            = c_q;
    flags_o[BIT_E]            = e_q;
  end
endmodule

// File: rtl/psf_flags_chk.sv
module psf_flags_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] acc_i,
  input logic              arith_vld,
  input logic              c14_i,
  input logic              c15_i,
  input logic              cmp_vld,
  input logic              cmp_eq,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic [7:0]        flags_o
);
  a_r1_reset_value: assert property (@(posedge clk) rst |=> flags_o == 8'h80);
  a_r2_zero_live: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> flags_o[7] == ($past(acc_i) == '0));
  a_r3_sign_live: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> flags_o[6] == $past(acc_i[DATA_W-1]));
  a_r4_ov_capture: assert property (@(posedge clk) disable iff (rst)
    arith_vld |=> flags_o[2] == ($past(c14_i) ^ $past(c15_i)));
  a_r4_ov_hold: assert property (@(posedge clk) disable iff (rst)
    !arith_vld |=> $stable(flags_o[2]));
  a_r5_carry_capture: assert property (@(posedge clk) disable iff (rst)
    arith_vld |=> flags_o[1] == $past(c15_i));
  a_r5_carry_sw: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !arith_vld) |=> flags_o[1] == $past(wr_data[1]));
  a_r6_eq_capture: assert property (@(posedge clk) disable iff (rst)
    cmp_vld |=> flags_o[0] == $past(cmp_eq));
  a_r6_eq_hold: assert property (@(posedge clk) disable iff (rst)
    (!cmp_vld && !wr_en) |=> $stable(flags_o[0]));
  a_r7_gpf_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> flags_o[4:3] == $past(wr_data[4:3]));
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    flags_o[5] == 1'b0);
endmodule

bind psf_flags psf_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .acc_i(acc_i), .arith_vld(arith_vld), .c14_i(c14_i),
  .c15_i(c15_i), .cmp_vld(cmp_vld), .cmp_eq(cmp_eq), .wr_en(wr_en),
  .wr_data(wr_data), .flags_o(flags_o)
);

// File: tb/sim_psf_flags.sv
`timescale 1ns/1ps
module sim_psf_flags;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] acc_i = '0;
  logic        arith_vld = 0, c14_i = 0, c15_i = 0, cmp_vld = 0, cmp_eq = 0, wr_en = 0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  flags_o;
  logic [7:0]  st;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  psf_flags u0 (
    .clk(clk), .rst(rst), .acc_i(acc_i), .arith_vld(arith_vld), .c14_i(c14_i),
    .c15_i(c15_i), .cmp_vld(cmp_vld), .cmp_eq(cmp_eq), .wr_en(wr_en),
    .wr_data(wr_data), .flags_o(flags_o)
  );

  function automatic logic [7:0] next_state(logic [7:0] s, logic [15:0] a, logic ar,
      logic k14, logic k15, logic cv, logic ce, logic we, logic [7:0] wd);
    logic [7:0] n;
    n = 8'h00;
    n[7] = (a == 16'h0);
    n[6] = a[15];
    n[4:3] = we ? wd[4:3] : s[4:3];
    n[2] = ar ? (k14 ^ k15) : s[2];
    n[1] = ar ? k15 : (we ? wd[1] : s[1]);
    n[0] = cv ? ce : (we ? wd[0] : s[0]);
    return n;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(logic [15:0] a, logic ar, logic k14, logic k15, logic cv,
      logic ce, logic we, logic [7:0] wd, string tag);
    @(negedge clk);
    acc_i = a; arith_vld = ar; c14_i = k14; c15_i = k15;
    cmp_vld = cv; cmp_eq = ce; wr_en = we; wr_data = wd;
    @(posedge clk);
    st = next_state(st, a, ar, k14, k15, cv, ce, we, wd);
    #1;
    check({tag, " R2 zero"}, {7'b0, flags_o[7]}, {7'b0, st[7]});
    check({tag, " R3 sign"}, {7'b0, flags_o[6]}, {7'b0, st[6]});
    check({tag, " R4 ov"}, {7'b0, flags_o[2]}, {7'b0, st[2]});
    check({tag, " R5 carry"}, {7'b0, flags_o[1]}, {7'b0, st[1]});
    check({tag, " R6 equals"}, {7'b0, flags_o[0]}, {7'b0, st[0]});
    check({tag, " R7 gpf"}, {6'b0, flags_o[4:3]}, {6'b0, st[4:3]});
    check({tag, " R8 reserved"}, {7'b0, flags_o[5]}, 8'h00);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    acc_i = 16'h1234;
    repeat (3) @(posedge clk);
    #1 check("R1 reset value", flags_o, 8'h80);
    @(negedge clk); rst = 0;
    st = 8'h80;
    step(16'h0000, 0,0,0, 0,0, 0,8'h00, "acc zero");
    step(16'h8000, 0,0,0, 0,0, 0,8'h00, "acc 8000");
    step(16'h0001, 0,0,0, 0,0, 0,8'h00, "acc 0001");
    step(16'hFFFF, 0,0,0, 0,0, 0,8'h00, "acc FFFF");
    step(16'h0005, 1,1,0, 0,0, 0,8'h00, "ov c14 only");
    step(16'h0005, 1,1,1, 0,0, 0,8'h00, "both carries");
    step(16'h0005, 1,0,1, 0,0, 0,8'h00, "ov c15 only");
    step(16'h0005, 1,0,0, 0,0, 0,8'h00, "no carries");
    step(16'h0005, 0,0,0, 0,0, 1,8'hFF, "R8 write all ones");
    check("R8 readonly bits ignore write", flags_o & 8'hE4, 8'h00);
    step(16'h0005, 0,0,0, 0,0, 1,8'h00, "write zeros");
    step(16'h0005, 1,0,0, 1,0, 1,8'h03, "R9 hw over sw clear");
    check("R9 priority zero", flags_o[1:0], 2'b00);
    step(16'h0005, 1,1,1, 1,1, 1,8'h00, "R9 hw over sw set");
    check("R9 priority one", flags_o[1:0], 2'b11);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      logic [15:0] a;
      r = $urandom;
      a = (r[31:29] == 0) ? 16'h0 : $urandom;
      step(a, r[0] & r[1], r[2], r[3], r[4] & r[5], r[6], r[7] & r[8], r[23:16], "random");
    end
    @(negedge clk); rst = 1;
    @(posedge clk); #1 check("R1 reset again", flags_o, 8'h80);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule